// File: doc/BRIEF.md
# PCI Host Interrupt Aggregation Register

This block collects the interrupt sources of a PCI host bridge into one 32-bit register and drives a single interrupt request. The sources are the four active-low INTx lines and six error events. Each source has a sticky pending flag in the lower half-word and an enable flag sixteen positions higher in the same word. A source is live only while both its pending flag and its enable flag are set. The request output goes high while any source is live.

Software writes the register to load the enables and to clear pending flags. A write of all zeros clears everything. The parameter `EXT_ERRORS` decides whether the three errors that not every bridge can detect are built. These are parity as master, signalled system error and detected parity. When the parameter is 0, only the three abort errors exist as error sources.

A small lookup also computes which INTx line a device's interrupt pin arrives on. The inputs are the device's slot number and its pin number. It uses the usual rotation by slot.

Top module: `pci_irq_agg`

## Requirements
- R1: Pending bit positions are INTA..INTD at bits 0..3. Error input `err_i[k]` lands at bit 4+k. In that order the errors are: parity detected as master (4), signalled target abort (5), received target abort (6), received master abort (7), signalled system error (8), detected parity (9).
- R2: A read returns the enables in bits 25:16 and the pending flags in bits 9:0. Bits 31:26 and 15:10 always read zero.
- R3: An INTx line passes through one sampling register. If the line is low at a rising edge, its pending bit is visible after the next rising edge and not before.
- R4: An error pending bit is set by a rising edge on its input, seen at the clock edge where the input is first high. An input held high does not set the bit again after it is cleared.
- R5: A non-zero write clears each pending bit whose position in bits 9:0 holds a 1. Pending bits at 0 positions are kept.
- R6: A write of all zeros clears every pending bit and every enable.
- R7: Every write loads the enables from bits 25:16 of the write data.
- R8: If a source sets its pending bit in the same cycle as a write that clears that bit, the bit stays set.
- R9: `irq_o` is high exactly when some source has both its pending bit and its enable bit set. It follows the register state in the cycle the register changes.
- R10: With `EXT_ERRORS` = 0, bits 4, 8 and 9 never become pending and their enables read zero. Bits 0..3 and 5..7 behave as with `EXT_ERRORS` = 1.
- R11: `swz_line_o` = ((pin-1) + (slot mod 4)) mod 4 for pin 1..4. Line 0 is INTA and line 3 is INTD.
- R12: After reset all pending bits, all enables and `irq_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Register read value |
| intx_ni | input | 4 | PCI INTA..INTD, active low |
| err_i | input | 6 | Error event inputs |
| irq_o | output | 1 | Combined interrupt request |
| swz_slot_i | input | SLOT_W | Device slot number for the lookup |
| swz_pin_i | input | 3 | Interrupt pin 1..4 for the lookup |
| swz_line_o | output | 2 | INTx line the pin arrives on |

## Verification
The bench goes after the following corner cases:

- **Set and clear in the same cycle.** A design where the clear wins would lose an event that arrives while software acknowledges it.
- **An error input held high across a clear.** Level-sensitive capture would cause an interrupt storm that software cannot acknowledge.
- **A zero write.** A design that treats it as a plain write-one-to-clear would leave stale pending flags behind.
- **INTx latency.** Being one cycle early or late shows up as a mismatch against the cycle model.
- **A build without the extended errors.** This must show inert bit positions in both halves of the word.
- **The slot rotation.** This is swept over all pins and several slots, to catch an off-by-one in the pin-to-line mapping.

// File: rtl/pci_irq_pkg.sv
package pci_irq_pkg;
  localparam int N_INTX   = 4;
  localparam int N_ERR    = 6;
  localparam int N_SRC    = N_INTX + N_ERR;
  localparam int MASK_OFS = 16;
  localparam int REG_W    = 32;
  // error sources always present: aborts (bits 5..7)
  localparam logic [N_SRC-1:0] BASE_BITS = 10'h0EF;
  // errors some bridges cannot detect (bits 4, 8, 9)
  localparam logic [N_SRC-1:0] EXT_BITS  = 10'h310;
endpackage

// File: rtl/irq_src_capture.sv
module irq_src_capture
  import pci_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_INTX-1:0] intx_ni,
  input  logic [N_ERR-1:0]  err_i,
  output logic [N_SRC-1:0]  set_o
);
  logic [N_INTX-1:0] intx_q;
  logic [N_ERR-1:0]  err_q;

  for (genvar i = 0; i < N_INTX; i++) begin : g_intx
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) intx_q[i] <= 1'b0;
      else         intx_q[i] <= ~intx_ni[i];
    assign set_o[i] = intx_q[i];
  end

  for (genvar k = 0; k < N_ERR; k++) begin : g_err
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) err_q[k] <= 1'b0;
      else         err_q[k] <= err_i[k];
    // rising edge only
    assign set_o[N_INTX+k] = err_i[k] & ~err_q[k];
  end
endmodule

// File: rtl/irq_pend_mask_reg.sv
module irq_pend_mask_reg
  import pci_irq_pkg::*;
#(
  parameter logic [N_SRC-1:0] IMPL = BASE_BITS | EXT_BITS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] set_i,
  input  logic             wr_en_i,
  input  logic             wr_zero_i,
  input  logic [N_SRC-1:0] wr_clr_i,
  input  logic [N_SRC-1:0] wr_mask_i,
  output logic [N_SRC-1:0] pend_o,
  output logic [N_SRC-1:0] mask_o
);
  logic [N_SRC-1:0] pend_q, pend_d, mask_q, mask_d;

  always_comb begin
    pend_d = pend_q;
    if (wr_en_i) pend_d = wr_zero_i ? '0 : (pend_q & ~wr_clr_i);
    pend_d = (pend_d | set_i) & IMPL;  // set wins over clear
    mask_d = wr_en_i ? (wr_mask_i & IMPL) : mask_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= pend_d;
      mask_q <= mask_d;
    end

  assign pend_o = pend_q;
  assign mask_o = mask_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_chk
    if (IMPL[i]) begin : g_impl
      a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[i] |=> pend_q[i]);
      a_r4_no_spurious_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pend_q[i]) |-> $past(set_i[i]));
      a_r5_clear_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !wr_zero_i && wr_clr_i[i] && !set_i[i]) |=> !pend_q[i]);
    end
  end

  a_r6_zero_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_zero_i && set_i == '0) |=> (pend_q == '0 && mask_q == '0));
  a_r7_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mask_q == ($past(wr_mask_i) & IMPL));
endmodule

// File: rtl/intx_swizzle.sv
module intx_swizzle #(
  parameter int SLOT_W = 5
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [2:0]        pin_i,
  output logic [1:0]        line_o
);
  // adding 3 is minus 1 modulo 4; truncation performs the modulo
  assign line_o = 2'(slot_i + SLOT_W'(pin_i) + SLOT_W'(3));
endmodule

// File: rtl/pci_irq_agg.sv
module pci_irq_agg
  import pci_irq_pkg::*;
#(
  parameter bit EXT_ERRORS = 1'b1,
  parameter int SLOT_W     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  output logic [31:0]       rd_data_o,
  input  logic [3:0]        intx_ni,
  input  logic [5:0]        err_i,
  output logic              irq_o,
  input  logic [SLOT_W-1:0] swz_slot_i,
  input  logic [2:0]        swz_pin_i,
  output logic [1:0]        swz_line_o
);
  localparam logic [N_SRC-1:0] IMPL = EXT_ERRORS ? (BASE_BITS | EXT_BITS) : BASE_BITS;
  localparam int GAP = MASK_OFS - N_SRC;
  localparam int TOP = REG_W - MASK_OFS - N_SRC;

  logic [N_SRC-1:0] set, pend, mask;
  logic             wr_zero;

  assign wr_zero = (wr_data_i == '0);

  irq_src_capture u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .intx_ni (intx_ni),
    .err_i   (err_i),
    .set_o   (set)
  );

  irq_pend_mask_reg #(.IMPL(IMPL)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set),
    .wr_en_i   (wr_en_i),
    .wr_zero_i (wr_zero),
    .wr_clr_i  (wr_data_i[N_SRC-1:0]),
    .wr_mask_i (wr_data_i[MASK_OFS+N_SRC-1:MASK_OFS]),
    .pend_o    (pend),
    .mask_o    (mask)
  );

  intx_swizzle #(.SLOT_W(SLOT_W)) u_swz (
    .slot_i (swz_slot_i),
    .pin_i  (swz_pin_i),
    .line_o (swz_line_o)
  );

  assign rd_data_o = {{TOP{1'b0}}, mask, {GAP{1'b0}}, pend};
  assign irq_o     = |(pend & mask);

  a_r9_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (rd_data_o[MASK_OFS+N_SRC-1:MASK_OFS] != '0));
  a_r10_ext_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend | mask) & ~IMPL) == '0);
endmodule

// File: tb/sim_pci_irq_agg.sv
module sim_pci_irq_agg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [3:0]  intx_n = 4'hF;
  logic [5:0]  err = '0;
  logic [4:0]  slot = '0;
  logic [2:0]  pin = 3'd1;
  logic [31:0] rd0, rd1;
  logic        irq0, irq1;
  logic [1:0]  line0, line1;
  int checks = 0, fails = 0;
  bit running = 1'b0;

  always #10 clk = ~clk;

  pci_irq_agg #(.EXT_ERRORS(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd0), .intx_ni(intx_n), .err_i(err), .irq_o(irq0),
    .swz_slot_i(slot), .swz_pin_i(pin), .swz_line_o(line0));

  pci_irq_agg #(.EXT_ERRORS(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd1), .intx_ni(intx_n), .err_i(err), .irq_o(irq1),
    .swz_slot_i(slot), .swz_pin_i(pin), .swz_line_o(line1));

  // behavioural reference model, one entry per instance
  bit [9:0] m_pend [2];
  bit [9:0] m_mask [2];
  bit [9:0] m_impl [2] = '{10'h3FF, 10'h0EF};
  bit [3:0] m_intx;
  bit [5:0] m_errp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < 2; n++) begin m_pend[n] = '0; m_mask[n] = '0; end
      m_intx = '0; m_errp = '0;
    end else begin
      for (int n = 0; n < 2; n++) begin
        bit [9:0] s;
        bit [9:0] p;
        s = {err & ~m_errp, m_intx} & m_impl[n];
        p = m_pend[n];
        if (wr_en) begin
          if (wr_data == 32'h0) p = '0;
          else p = p & ~wr_data[9:0];
          m_mask[n] = wr_data[25:16] & m_impl[n];
        end
        m_pend[n] = (p | s) & m_impl[n];
      end
      m_intx = ~intx_n;
      m_errp = err;
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (running && rst_n) begin
      chk("R2 model u0 rd", rd0, {6'b0, m_mask[0], 6'b0, m_pend[0]});
      chk("R2 model u1 rd", rd1, {6'b0, m_mask[1], 6'b0, m_pend[1]});
      chk("R9 model u0 irq", 32'(irq0), 32'(|(m_pend[0] & m_mask[0])));
      chk("R9 model u1 irq", 32'(irq1), 32'(|(m_pend[1] & m_mask[1])));
    end
  end

  task automatic wr(logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit [9:0] acc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    running = 1'b1;
    @(negedge clk);
    chk("R12 reset rd", rd0, 32'h0);
    chk("R12 reset irq", 32'(irq0), 32'h0);

    wr(32'h03FF_0000);
    chk("R7 mask load", rd0, 32'h03FF_0000);
    chk("R10 u1 mask", rd1, 32'h00EF_0000);

    acc = '0;
    for (int k = 0; k < 6; k++) begin
      err[k] = 1'b1;
      @(negedge clk);
      err[k] = 1'b0;
      acc |= 10'(1 << (4 + k));
      chk("R1 err position", rd0, {16'h03FF, 6'b0, acc});
      chk("R9 irq on error", 32'(irq0), 32'h1);
    end
    chk("R10 u1 ext errors dropped", rd1, 32'h00EF_00E0);

    wr(32'h03FF_03F0);
    chk("R5 clear all errors", rd0, 32'h03FF_0000);
    chk("R9 irq low when clear", 32'(irq0), 32'h0);

    err[1] = 1'b1;
    @(negedge clk);
    chk("R4 rising edge", rd0, 32'h03FF_0020);
    wr(32'h03FF_0020);
    @(negedge clk);
    chk("R4 held level no reset", rd0, 32'h03FF_0000);
    err[1] = 1'b0;

    err = 6'b001100;
    @(negedge clk);
    err = '0;
    wr(32'h03FF_0040);
    chk("R5 partial clear", rd0, 32'h03FF_0080);

    intx_n[2] = 1'b0;
    @(negedge clk);
    chk("R3 not yet pending", rd0, 32'h03FF_0080);
    @(negedge clk);
    chk("R3 INTC pending", rd0, 32'h03FF_0084);
    intx_n[2] = 1'b1;
    @(negedge clk);
    wr(32'h03FF_0004);
    chk("R5 INTC cleared", rd0, 32'h03FF_0080);

    err[0] = 1'b1; wr_en = 1'b1; wr_data = 32'h03FF_0010;
    @(negedge clk);
    err[0] = 1'b0; wr_en = 1'b0; wr_data = '0;
    chk("R8 set beats clear", rd0, 32'h03FF_0090);

    wr(32'h0080_0000);
    chk("R9 enabled bit7", rd0, 32'h0080_0090);
    chk("R9 irq bit7", 32'(irq0), 32'h1);
    wr(32'h0200_0000);
    chk("R9 irq masked", 32'(irq0), 32'h0);

    wr(32'h0000_0000);
    chk("R6 zero write u0", rd0, 32'h0);
    chk("R6 zero write u1", rd1, 32'h0);

    wr(32'hFFFF_FC00);
    chk("R2 reserved zero", rd0, 32'h03FF_0000);
    intx_n[0] = 1'b0;
    repeat (2) @(negedge clk);
    intx_n[0] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 INTA bit0", rd0, 32'h03FF_0001);
    chk("R10 u1 INTA kept", rd1, 32'h00EF_0001);
    wr(32'h0);

    for (int s = 0; s < 8; s++) begin
      for (int p = 1; p <= 4; p++) begin
        slot = 5'(s); pin = 3'(p);
        #1;
        chk("R11 swizzle", 32'(line0), 32'(((p - 1) + (s % 4)) % 4));
      end
    end

    @(negedge clk);
    running = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule